// File: doc/BRIEF.md
# Two-Rate Three-Color Packet Meter

This block meters an ingress packet stream against two token buckets. One bucket holds committed tokens and the other holds peak (excess) tokens. Each packet appears for one cycle as a length with a valid strobe. The meter works out the packet's token cost, marks it green, yellow or red, and takes tokens from each bucket that conforms. One registered cycle later it reports the colour and a pass/drop verdict, which it reads from a per-colour action table. The meter is colour-blind: the incoming traffic carries no prior colour.

Rates, burst caps and the cost adjustment all use a floating-point-like code of the form (1 + M/256) * 2^E tokens. An exponent of 24 or more gives zero, and a bucket whose burst cap is zero is switched off. The buckets refill together on a time base. A prescaler turns clock cycles into one time unit, and a power-of-two divider stretches that unit. A length-mode bit, combined with the adjust term, turns byte metering into one-token-per-packet metering. All configuration arrives on static input pins.

Top module: `trtcm_policer`

## Requirements
- R1: Token quantities are kept in units of 1/256 token. A code (M, E) is worth (256+M)*2^E units when E < 24 and is worth 0 when E >= 24. A bucket whose burst code is worth 0 never holds tokens.
- R2: With TICK_CYCLES clock cycles per time unit, counting cycle 0 as the first cycle after reset is released, a refill takes place in every cycle c where c mod (TICK_CYCLES*2^rdiv) equals TICK_CYCLES*2^rdiv - 1. Each refill adds the rate value to each bucket and caps the result at that bucket's burst value.
- R3: When a refill and a packet fall in the same cycle, the refill is applied first, and the packet is judged against the refilled levels.
- R4: In byte mode (lmode=0) the cost in units is (len - offset)*256 + (adj_m - 256)*2^adj_e, with signed arithmetic. Any result below 1 unit is raised to 1 unit.
- R5: In packet mode (lmode=1) the length and offset are ignored. With adj_m=384 and adj_e=1, every packet costs exactly 256 units (one token).
- R6: If the peak bucket holds less than the cost, the packet is red and no tokens are taken. If the peak bucket holds enough but the committed bucket does not, the packet is yellow and only the peak bucket is charged. If both hold enough, the packet is green and both buckets are charged.
- R7: When the peak bucket is switched off (burst value 0), the colour depends only on the committed bucket: green if it conforms, red if not. Yellow never appears.
- R8: Colours are encoded green=0, yellow=1, red=2. cfg_act holds a 2-bit action per colour: bits [1:0] for green, [3:2] for yellow and [5:4] for red. An action of 00 means pass, and any other action means drop.
- R9: A result (res_valid, res_color, res_pass) appears in the cycle after a packet's valid cycle, and res_valid is low in the cycle after a cycle with no packet.
- R10: Reset empties both buckets and clears res_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cir_m | input | 8 | Committed rate mantissa |
| cfg_cir_e | input | 5 | Committed rate exponent |
| cfg_cbs_m | input | 8 | Committed burst mantissa |
| cfg_cbs_e | input | 5 | Committed burst exponent |
| cfg_pir_m | input | 8 | Peak rate mantissa |
| cfg_pir_e | input | 5 | Peak rate exponent |
| cfg_pbs_m | input | 8 | Peak burst mantissa |
| cfg_pbs_e | input | 5 | Peak burst exponent |
| cfg_rdiv | input | 4 | Refill interval, log2 of the number of time units |
| cfg_lmode | input | 1 | 1 = packet-count costing, 0 = byte costing |
| cfg_len_off | input | LEN_W | Length offset subtracted in byte mode |
| cfg_adj_m | input | 9 | Cost adjust mantissa |
| cfg_adj_e | input | 5 | Cost adjust exponent |
| cfg_act | input | 6 | Per-colour action table |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_len | input | LEN_W | Packet length in bytes |
| res_valid | output | 1 | Result present |
| res_color | output | 2 | Colour of the metered packet |
| res_pass | output | 1 | 1 = pass, 0 = drop |

## Verification
A refill and a packet can fall in the same clock cycle. The order of those two events decides whether a packet that arrives at an empty bucket is coloured by the tokens that have just been added. The bench provokes this by using a short prescaler and sending packets on exactly the cycle its own cycle counter marks as a refill cycle. Some of these packets, both directed and random, cost exactly what one refill supplies. The bench's reference model refills first and then meters, so a green result at an empty bucket shows the correct order, and any other colour is reported against R3 or R6.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int MAN_W   = 8;
  localparam int EXP_W   = 5;
  localparam int ADJ_W   = 9;
  localparam int DIV_W   = 4;
  localparam int FRAC_W  = 8;
  localparam int OFF_EXP = 24;
  localparam int TOK_W   = FRAC_W + 1 + (OFF_EXP - 1) + 2;
  localparam int COST_W  = 48;

  typedef enum logic [1:0] {
    CLR_GREEN  = 2'd0,
    CLR_YELLOW = 2'd1,
    CLR_RED    = 2'd2
  } color_e;

  // (1 + m/256) * 2^e tokens, expressed in 1/256-token units
  function automatic logic [TOK_W-1:0] tok_val(input logic [MAN_W-1:0] m,
                                               input logic [EXP_W-1:0] e);
    if (int'(e) >= OFF_EXP) return '0;
    return TOK_W'({1'b1, m}) << e;
  endfunction
endpackage

// File: rtl/tcm_tick_gen.sv
module tcm_tick_gen #(
  parameter int TICK_CYCLES = 250,
  parameter int DIV_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] rdiv,
  output logic             refill
);
  localparam int PRE_W  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int DCNT_W = 2 ** DIV_W;

  logic [PRE_W-1:0]  pre_q;
  logic [DCNT_W-1:0] div_q;
  logic [DCNT_W-1:0] div_lim;
  logic              unit_tick;

  assign unit_tick = (pre_q == PRE_W'(TICK_CYCLES - 1));
  assign div_lim   = (DCNT_W'(1) << rdiv) - DCNT_W'(1);
  assign refill    = unit_tick && (div_q >= div_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= unit_tick ? '0 : pre_q + PRE_W'(1);
      if (unit_tick) div_q <= (div_q >= div_lim) ? '0 : div_q + DCNT_W'(1);
    end
  end

  generate
    if (TICK_CYCLES > 1) begin : g_spacing
      assert_refill_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        refill |=> !refill);
    end
  endgenerate
endmodule

// File: rtl/tcm_cost.sv
module tcm_cost import tcm_pkg::*; #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [LEN_W-1:0]  off,
  input  logic              lmode,
  input  logic [ADJ_W-1:0]  adj_m,
  input  logic [EXP_W-1:0]  adj_e,
  output logic [COST_W-1:0] cost
);
  logic signed [COST_W-1:0] len_part, adj_part, total;

  always_comb begin
    if (lmode) len_part = '0;
    else len_part = ($signed({{(COST_W-LEN_W){1'b0}}, len}) -
                     $signed({{(COST_W-LEN_W){1'b0}}, off})) <<< FRAC_W;
    adj_part = ($signed({{(COST_W-ADJ_W){1'b0}}, adj_m}) -
                $signed(COST_W'(256))) <<< adj_e;
    total    = len_part + adj_part;
    cost     = (total < $signed(COST_W'(1))) ? COST_W'(1) : $unsigned(total);
  end

  always_comb begin
    assert_cost_min_R4: assert (cost != '0);
  end
endmodule

// File: rtl/tcm_bucket.sv
module tcm_bucket import tcm_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              refill,
  input  logic [TOK_W-1:0]  rate,
  input  logic [TOK_W-1:0]  cap,
  input  logic [COST_W-1:0] cost,
  input  logic              deduct,
  output logic [TOK_W-1:0]  avail,
  output logic              ok
);
  logic [TOK_W-1:0] level_q, sum;

  assign sum   = level_q + rate;
  assign avail = refill ? ((sum > cap) ? cap : sum) : level_q;
  assign ok    = {{(COST_W-TOK_W){1'b0}}, avail} >= cost;

  always_ff @(posedge clk) begin
    if (rst)         level_q <= '0;
    else if (deduct) level_q <= avail - cost[TOK_W-1:0];
    else             level_q <= avail;
  end

  assert_level_capped_R2: assert property (@(posedge clk) disable iff (rst)
    refill |=> level_q <= $past(cap));
  assert_no_growth_R6: assert property (@(posedge clk) disable iff (rst)
    !refill |=> level_q <= $past(level_q));
  assert_deduct_covered_R6: assert property (@(posedge clk) disable iff (rst)
    deduct |-> {{(COST_W-TOK_W){1'b0}}, avail} >= cost);
endmodule

// File: rtl/trtcm_policer.sv
module trtcm_policer import tcm_pkg::*; #(
  parameter int TICK_CYCLES = 250,
  parameter int LEN_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       cfg_cir_m,
  input  logic [4:0]       cfg_cir_e,
  input  logic [7:0]       cfg_cbs_m,
  input  logic [4:0]       cfg_cbs_e,
  input  logic [7:0]       cfg_pir_m,
  input  logic [4:0]       cfg_pir_e,
  input  logic [7:0]       cfg_pbs_m,
  input  logic [4:0]       cfg_pbs_e,
  input  logic [3:0]       cfg_rdiv,
  input  logic             cfg_lmode,
  input  logic [LEN_W-1:0] cfg_len_off,
  input  logic [8:0]       cfg_adj_m,
  input  logic [4:0]       cfg_adj_e,
  input  logic [5:0]       cfg_act,
  input  logic             pkt_valid,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             res_valid,
  output logic [1:0]       res_color,
  output logic             res_pass
);
  localparam int NB = 2;  // index 0 committed, 1 peak

  logic              refill;
  logic [COST_W-1:0] cost;
  logic [TOK_W-1:0]  rate [NB];
  logic [TOK_W-1:0]  cap  [NB];
  logic [TOK_W-1:0]  avail[NB];
  logic [NB-1:0]     ok, deduct;
  logic              peak_off;
  color_e            color;
  logic [1:0]        act;

  assign rate[0] = tok_val(cfg_cir_m, cfg_cir_e);
  assign cap[0]  = tok_val(cfg_cbs_m, cfg_cbs_e);
  assign rate[1] = tok_val(cfg_pir_m, cfg_pir_e);
  assign cap[1]  = tok_val(cfg_pbs_m, cfg_pbs_e);

  tcm_tick_gen #(.TICK_CYCLES(TICK_CYCLES), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .rdiv(cfg_rdiv), .refill(refill));

  tcm_cost #(.LEN_W(LEN_W)) u_cost (
    .len(pkt_len), .off(cfg_len_off), .lmode(cfg_lmode),
    .adj_m(cfg_adj_m), .adj_e(cfg_adj_e), .cost(cost));

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bkt
      tcm_bucket u_bkt (
        .clk(clk), .rst(rst), .refill(refill), .rate(rate[b]), .cap(cap[b]),
        .cost(cost), .deduct(deduct[b]), .avail(avail[b]), .ok(ok[b]));
    end
  endgenerate

  assign peak_off = (cap[1] == '0);

  always_comb begin
    if (peak_off)   color = ok[0] ? CLR_GREEN : CLR_RED;
    else if (!ok[1]) color = CLR_RED;
    else if (!ok[0]) color = CLR_YELLOW;
    else             color = CLR_GREEN;
    deduct[0] = pkt_valid && (color == CLR_GREEN) && ok[0];
    deduct[1] = pkt_valid && (color != CLR_RED) && ok[1];
    case (color)
      CLR_GREEN:  act = cfg_act[1:0];
      CLR_YELLOW: act = cfg_act[3:2];
      default:    act = cfg_act[5:4];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_color <= 2'd0;
      res_pass  <= 1'b0;
    end else begin
      res_valid <= pkt_valid;
      if (pkt_valid) begin
        res_color <= color;
        res_pass  <= (act == 2'b00);
      end
    end
  end

  assert_result_follows_R9: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> res_valid);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid |=> !res_valid);
  assert_legal_color_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_color != 2'd3);
  assert_no_yellow_R7: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && peak_off) |=> res_color != 2'd1);
endmodule

// File: tb/tb_trtcm_policer.sv
module tb_trtcm_policer;
  localparam int TICK  = 4;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] cir_m, cbs_m, pir_m, pbs_m;
  logic [4:0] cir_e, cbs_e, pir_e, pbs_e, adj_e;
  logic [3:0] rdiv;
  logic lmode;
  logic [LEN_W-1:0] off, pkt_len;
  logic [8:0] adj_m;
  logic [5:0] act;
  logic pkt_valid;
  logic res_valid, res_pass;
  logic [1:0] res_color;

  int checks = 0, failures = 0;
  longint mc, mp;
  int cnt;

  always #4 clk = ~clk;

  trtcm_policer #(.TICK_CYCLES(TICK), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst), .cfg_cir_m(cir_m), .cfg_cir_e(cir_e),
    .cfg_cbs_m(cbs_m), .cfg_cbs_e(cbs_e), .cfg_pir_m(pir_m), .cfg_pir_e(pir_e),
    .cfg_pbs_m(pbs_m), .cfg_pbs_e(pbs_e), .cfg_rdiv(rdiv), .cfg_lmode(lmode),
    .cfg_len_off(off), .cfg_adj_m(adj_m), .cfg_adj_e(adj_e), .cfg_act(act),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len), .res_valid(res_valid),
    .res_color(res_color), .res_pass(res_pass));

  function automatic longint tv(input int m, input int e);
    if (e >= 24) return 0;
    return longint'(256 + m) << e;
  endfunction

  function automatic longint cost_of(input int len);
    longint lp, ap, s;
    lp = lmode ? 0 : (longint'(len) - longint'(off)) * 256;
    ap = (longint'(adj_m) - 256) * (longint'(1) << adj_e);
    s  = lp + ap;
    return (s < 1) ? 1 : s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pkt_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mc = 0; mp = 0; cnt = 0;
    checks++;
    if (res_valid !== 1'b0) begin
      failures++;
      $display("FAIL R10 res_valid after reset: actual %0b expected 0", res_valid);
    end
  endtask

  task automatic step(input bit v, input int len, input string tag);
    longint per, ca, pa, cst;
    bit rf, cok, pok;
    int ecol;
    bit epass;
    per = longint'(TICK) << rdiv;
    rf  = (longint'(cnt) % per) == per - 1;
    ca  = mc; pa = mp;
    if (rf) begin
      ca = (mc + tv(cir_m, cir_e) > tv(cbs_m, cbs_e)) ? tv(cbs_m, cbs_e) : mc + tv(cir_m, cir_e);
      pa = (mp + tv(pir_m, pir_e) > tv(pbs_m, pbs_e)) ? tv(pbs_m, pbs_e) : mp + tv(pir_m, pir_e);
    end
    cst = cost_of(len);
    cok = ca >= cst; pok = pa >= cst;
    if (tv(pbs_m, pbs_e) == 0) ecol = cok ? 0 : 2;
    else if (!pok) ecol = 2;
    else if (!cok) ecol = 1;
    else ecol = 0;
    epass = (((act >> (2 * ecol)) & 6'd3) == 6'd0);
    pkt_valid = v; pkt_len = LEN_W'(len);
    @(posedge clk);
    cnt++;
    mc = ca; mp = pa;
    if (v && ecol == 0) mc = ca - cst;
    if (v && ecol != 2) mp = pa - cst;
    @(negedge clk);
    pkt_valid = 1'b0;
    checks++;
    if (res_valid !== v) begin
      failures++;
      $display("FAIL %s res_valid: actual %0b expected %0b", tag, res_valid, v);
    end else if (v && (res_color !== 2'(ecol) || res_pass !== epass)) begin
      failures++;
      $display("FAIL %s color/pass: actual %0d/%0b expected %0d/%0b",
               tag, res_color, res_pass, ecol, epass);
    end
  endtask

  task automatic base_cfg();
    cir_m = 0; cir_e = 4;  cbs_m = 0; cbs_e = 10;
    pir_m = 0; pir_e = 5;  pbs_m = 0; pbs_e = 11;
    rdiv = 0; lmode = 0; off = 0; adj_m = 256; adj_e = 0;
    act = 6'b01_00_00;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    pkt_valid = 0; pkt_len = 0;
    base_cfg();
    do_reset();
    step(1, 1, "R10");          // empty buckets: red
    step(0, 0, "R9");
    step(0, 0, "R9");
    step(1, 16, "R3");          // refill cycle, cost equals committed refill
    step(1, 8, "R6");           // committed empty -> yellow
    step(1, 16, "R6");          // peak short -> red
    for (int i = 0; i < 400; i++) step(0, 0, "R2");
    step(1, 1024, "R2");        // exactly the committed cap
    step(1, 1, "R2");
    step(1, 2048, "R2");
    // byte-mode cost corners
    off = 20; step(1, 10, "R4");
    adj_m = 300; adj_e = 2; step(1, 30, "R4");
    adj_m = 0; adj_e = 3; step(1, 25, "R4");
    // packet mode
    base_cfg(); cir_e = 8; cbs_e = 9; pir_e = 8; pbs_e = 10;
    lmode = 1; adj_m = 384; adj_e = 1; off = 100;
    do_reset();
    for (int i = 0; i < 40; i++) step(1, 60000 - i, "R5");
    // peak bucket off
    base_cfg(); pir_e = 24; pbs_e = 24; act = 6'b01_10_11;
    do_reset();
    for (int i = 0; i < 60; i++) step(i % 3 != 0, 4 + (i % 20), "R7");
    // committed bucket off
    base_cfg(); cir_e = 24; cbs_e = 24;
    do_reset();
    for (int i = 0; i < 60; i++) step(i % 2 == 0, 8 + (i % 30), "R1");
    // action tables
    base_cfg(); rdiv = 1;
    do_reset();
    for (int i = 0; i < 64; i++) begin
      act = 6'(i);
      step(1, 6 + (i % 12), "R8");
    end
    // random configurations
    for (int k = 0; k < 6; k++) begin
      cir_m = 8'($urandom); cir_e = 5'($urandom_range(2, 10));
      cbs_m = 8'($urandom); cbs_e = 5'($urandom_range(10, 16));
      pir_m = 8'($urandom); pir_e = 5'($urandom_range(3, 11));
      pbs_m = 8'($urandom); pbs_e = (k == 5) ? 5'd24 : 5'($urandom_range(11, 17));
      rdiv = 4'($urandom_range(0, 2)); lmode = (k == 4);
      off = LEN_W'($urandom_range(0, 20));
      adj_m = (k == 4) ? 9'd384 : 9'($urandom_range(200, 300));
      adj_e = (k == 4) ? 5'd1 : 5'($urandom_range(0, 4));
      act = 6'($urandom);
      do_reset();
      for (int i = 0; i < 500; i++)
        step(($urandom % 2) == 1, int'($urandom_range(0, 1500)), "R6");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule